// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system bus and an external asynchronous static RAM of 512K bytes. The RAM has a 19-bit address, one shared 8-bit data bus, and three active-low strobes: chip select, write enable and output enable. A requester offers one read or write at a time with a valid/ready handshake. The controller generates the strobe sequence for that access. It holds every phase for a whole number of clock cycles, chosen from the RAM's minimum timings, and returns a one-cycle acknowledge. A read's acknowledge carries the captured byte.

The shared data bus is split at the block edge into an output word, an output-enable and an input word. The output enable drives the pad tristate. The controller keeps the RAM's output enable high for the whole of every write, which allows the shorter write pulse. When a write follows a read, it waits an extra turnaround period before it drives the bus, so the RAM and the controller never drive the bus together. All timing values are parameters in nanoseconds, together with the clock period. Each phase takes the matching time divided by the period, rounded up, with a minimum of one cycle.

Top module: `asram_ctl`

## Requirements
- R1: While reset is high, and after it is released, chip select, write enable and output enable are high, the data driver is off, acknowledge is low and ready is high.
- R2: A write runs in this order: one setup cycle with chip select low and write enable high, then write enable low for ceil(max(write pulse, data setup)/clock) cycles (2 at the defaults), then one recovery cycle with write enable high and chip select still low. The controller drives the data bus in all three phases.
- R3: Output enable is high in every cycle in which write enable is low.
- R4: A read holds chip select and output enable low, with write enable high and a steady address, for exactly ceil(max(read cycle, address access, output-enable access)/clock) cycles (2 at the defaults). The byte on the bus is captured on the clock edge that ends this phase.
- R5: Acknowledge is high for exactly one cycle, in the cycle after the access's last phase. It comes 5 cycles after acceptance for a write and 3 cycles for a read at the defaults, plus the turnaround of R6 where it applies. On a read acknowledge, the read-data output equals the byte last written to that address.
- R6: When a write follows a read, output enable has been high and the data driver off for at least 1 + ceil(output-disable time/clock) cycles (2 at the defaults) before the driver turns on. The data driver is never on while output enable is low.
- R7: Ready is high only while idle. A request is taken only when valid and ready are both high. Ready is low from the cycle after acceptance until the acknowledge has been given.
- R8: Address and write data stay unchanged from the cycle chip select falls until it rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 8 | Captured read byte, valid with ack |
| ram_addr | output | 19 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Byte driven toward the RAM |
| ram_dq_oe | output | 1 | Enable of the controller's bus driver |
| ram_dq_in | input | 8 | Byte read from the RAM bus |

## Verification
The hardest situation to reach is a write issued directly after a read. Only in that case does the RAM's lingering output overlap the controller's driver, and only then does the turnaround wait matter. The stimulus alternates reads and writes back to back, with reads of the same and of different addresses in between. The behavioural RAM in the bench keeps driving the bus for one sample after output enable rises. It returns corrupted data until the access time has elapsed, so both a shortened turnaround and an early capture become visible at the ports.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WREC = 3'd4,
    ST_RACC = 3'd5,
    ST_DONE = 3'd6
  } ctl_state_t;

  // whole cycles covering a time in ns, never below one
  function automatic int unsigned ns_to_cycles(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned n);
    return $clog2(n + 1) + 1;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_ctl_fsm.sv
module asram_ctl_fsm
  import asram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned TA_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output ctl_state_t       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             evt_accept,
  output logic             evt_capture,
  output logic             req_ready,
  output logic             ack,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  ctl_state_t state_q, state_d;
  logic       last_rd_q;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    evt_accept  = 1'b0;
    evt_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          evt_accept = 1'b1;
          if (req_write) begin
            if (last_rd_q) begin
              state_d  = ST_TURN;
              tmr_load = 1'b1;
              tmr_val  = TA_LD;
            end else begin
              state_d = ST_WSET;
            end
          end else begin
            state_d  = ST_RACC;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_TURN: if (tmr_expired) state_d = ST_WSET;
      ST_WSET: begin
        state_d  = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      ST_WPUL: if (tmr_expired) state_d = ST_WREC;
      ST_WREC: state_d = ST_DONE;
      ST_RACC: begin
        if (tmr_expired) begin
          state_d     = ST_DONE;
          evt_capture = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt_accept) last_rd_q <= !req_write;
    end
  end

  assign state     = state_q;
  assign req_ready = (state_q == ST_IDLE);
  assign ack       = (state_q == ST_DONE);
  assign cs_n      = !(state_q inside {ST_WSET, ST_WPUL, ST_WREC, ST_RACC});
  assign we_n      = (state_q != ST_WPUL);
  assign oe_n      = (state_q != ST_RACC);
  assign dq_oe     = (state_q inside {ST_WSET, ST_WPUL, ST_WREC});

endmodule

// File: rtl/asram_ctl_dp.sv
module asram_ctl_dp #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_accept,
  input  logic              evt_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (evt_accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata_q <= '0;
    else if (evt_capture) rdata_q <= bus_in;
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rdata_out = rdata_q;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 5,
  parameter int unsigned TWP_NS  = 7,
  parameter int unsigned TDW_NS  = 5,
  parameter int unsigned TWC_NS  = 10,
  parameter int unsigned TRC_NS  = 10,
  parameter int unsigned TAA_NS  = 10,
  parameter int unsigned TOE_NS  = 5,
  parameter int unsigned TOHZ_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  // setup and recovery take one cycle each; the pulse fills the rest of the write cycle
  localparam int unsigned WC_CYC = ns_to_cycles(TWC_NS, CLK_NS);
  localparam int unsigned WP_CYC = umax(umax(ns_to_cycles(TWP_NS, CLK_NS),
                                             ns_to_cycles(TDW_NS, CLK_NS)),
                                        (WC_CYC > 2) ? WC_CYC - 2 : 1);
  localparam int unsigned RD_CYC = ns_to_cycles(umax(umax(TRC_NS, TAA_NS), TOE_NS), CLK_NS);
  localparam int unsigned TA_CYC = ns_to_cycles(TOHZ_NS, CLK_NS);
  localparam int unsigned CNT_W  = cnt_bits(umax(umax(WP_CYC, RD_CYC), TA_CYC));

  ctl_state_t       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             evt_accept;
  logic             evt_capture;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_ctl_fsm #(
    .CNT_W  (CNT_W),
    .WP_CYC (WP_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .evt_accept  (evt_accept),
    .evt_capture (evt_capture),
    .req_ready   (req_ready),
    .ack         (ack),
    .cs_n        (ram_cs_n),
    .we_n        (ram_we_n),
    .oe_n        (ram_oe_n),
    .dq_oe       (ram_dq_oe)
  );

  asram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .evt_accept  (evt_accept),
    .evt_capture (evt_capture),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .bus_in      (ram_dq_in),
    .addr_out    (ram_addr),
    .wdata_out   (ram_dq_out),
    .rdata_out   (ack_rdata)
  );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned TA_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ram_cs_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ack,
  input logic              req_ready
);

  logic [7:0] wlow_cnt;
  logic [7:0] oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   wlow_cnt <= '0;
    else if (!ram_we_n)        wlow_cnt <= (wlow_cnt == 8'hFF) ? wlow_cnt : wlow_cnt + 8'd1;
    else                       wlow_cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   oe_hi_cnt <= 8'hFF;
    else if (!ram_oe_n)        oe_hi_cnt <= '0;
    else                       oe_hi_cnt <= (oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1;
  end

  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> ram_oe_n);

  assert_we_after_cs_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $past(!ram_cs_n));

  assert_cs_held_past_we_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> !ram_cs_n);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (wlow_cnt >= WP_CYC));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> ram_oe_n);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> (oe_hi_cnt >= TA_CYC + 1));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    ack |-> !req_ready);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) u_chk (.*);

// File: tb/asram_ctl_test.sv
`timescale 1ns/1ps
module asram_ctl_test;

  localparam int CLK_NS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, ack;
  logic [7:0]  ack_rdata;
  logic [18:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [7:0]  ram_dq_out;
  logic [7:0]  ram_dq_in;

  always #2.5 clk = ~clk;

  asram_ctl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack(ack), .ack_rdata(ack_rdata), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // cycles needed, counted upward from one
  function automatic int need(int t_ns);
    int n = 1;
    while (n * CLK_NS < t_ns) n++;
    return n;
  endfunction

  int WP_NEED, RD_NEED, TA_NEED;
  int total = 0, bad = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural RAM
  logic [7:0]  mem [int];
  logic [7:0]  refm [int];
  logic [7:0]  ram_out = 8'h00;
  bit          prev_rd = 0, prev_wr = 0, prev_dqoe = 0;
  logic [18:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;
  int          rd_cnt = 0, wcnt = 0, gap = 100;
  int          last_rd_len = 0, last_wp_len = 0, last_gap = 0;
  bit          contention = 0, oe_bad = 0, unstable = 0;

  assign ram_dq_in = ram_out;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    bit rd_now, wr_now;
    if (rst) begin
      prev_rd = 0; prev_wr = 0; prev_dqoe = 0; rd_cnt = 0; wcnt = 0; gap = 100;
      ram_out = 8'h00;
    end else begin
      rd_now = !ram_cs_n && ram_we_n && !ram_oe_n;
      wr_now = !ram_cs_n && !ram_we_n;
      if (rd_now) rd_cnt = (prev_rd && ram_addr == prev_addr) ? rd_cnt + 1 : 1;
      else begin
        if (prev_rd) last_rd_len = rd_cnt;
        rd_cnt = 0;
      end
      if (rd_now) ram_out = (rd_cnt >= RD_NEED) ? mem_rd(ram_addr) : ~mem_rd(ram_addr);
      else ram_out = 8'h00;
      if ((rd_now || prev_rd) && ram_dq_oe) contention = 1;
      if (wr_now && !ram_oe_n) oe_bad = 1;
      if (wr_now && prev_wr && (ram_addr != prev_addr || ram_dq_out != prev_dq)) unstable = 1;
      if (wr_now) wcnt++;
      else begin
        if (prev_wr) begin
          last_wp_len = wcnt;
          mem[int'(prev_addr)] = prev_dq;
        end
        wcnt = 0;
      end
      if (ram_dq_oe && !prev_dqoe) last_gap = gap;
      if (rd_now) gap = 0;
      else if (!ram_dq_oe && ram_oe_n) gap++;
      prev_rd = rd_now; prev_wr = wr_now; prev_dqoe = ram_dq_oe;
      prev_addr = ram_addr; prev_dq = ram_dq_out;
    end
  end

  // scoreboard
  typedef struct {
    bit          wr;
    logic [18:0] a;
    logic [7:0]  d;
    int          lat;
    int          t0;
    bit          after_rd;
  } exp_t;
  exp_t q[$];
  bit   last_kind_rd = 0;

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    e.wr = wr; e.a = a; e.t0 = cyc; e.after_rd = wr && last_kind_rd;
    if (wr) begin
      refm[int'(a)] = d;
      e.d = d;
      e.lat = 1 + WP_NEED + 1 + 1 + (e.after_rd ? TA_NEED : 0);
    end else begin
      e.d = refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
      e.lat = RD_NEED + 1;
    end
    last_kind_rd = !wr;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    check(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst && ack) begin
      if (q.size() == 0) check(0, "R5 unexpected ack", 1, 0);
      else begin
        e = q.pop_front();
        check(cyc - e.t0 == e.lat, "R5 ack latency", cyc - e.t0, e.lat);
        check(req_ready == 1'b0, "R7 not ready during ack", req_ready, 0);
        check(!contention, "R6 bus contention", contention, 0);
        if (e.wr) begin
          check(last_wp_len == WP_NEED, "R2 write pulse cycles", last_wp_len, WP_NEED);
          check(!oe_bad, "R3 oe low during write", oe_bad, 0);
          check(!unstable, "R8 addr/data moved during write", unstable, 0);
          check(mem_rd(e.a) == e.d, "R2 RAM content after write", mem_rd(e.a), e.d);
          if (e.after_rd)
            check(last_gap >= 1 + TA_NEED, "R6 turnaround cycles", last_gap, 1 + TA_NEED);
        end else begin
          check(last_rd_len == RD_NEED, "R4 read access cycles", last_rd_len, RD_NEED);
          check(ack_rdata == e.d, "R5 read data", ack_rdata, e.d);
        end
      end
    end
  end

  initial begin
    #(100000 * CLK_NS);
    check(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    WP_NEED = need(7);
    if (need(5) > WP_NEED) WP_NEED = need(5);
    RD_NEED = need(10);
    TA_NEED = need(5);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(ram_cs_n && ram_we_n && ram_oe_n, "R1 strobes high in reset",
          {ram_cs_n, ram_we_n, ram_oe_n}, 3'b111);
    check(!ram_dq_oe && !ack, "R1 driver off, no ack in reset", {ram_dq_oe, ack}, 0);
    rst = 0;
    @(negedge clk);
    check(ram_cs_n && ram_we_n && ram_oe_n, "R1 strobes high after reset",
          {ram_cs_n, ram_we_n, ram_oe_n}, 3'b111);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(!ram_dq_oe, "R1 driver off after reset", ram_dq_oe, 0);

    do_req(1, 19'h00000, 8'h3C);
    do_req(1, 19'h7FFFF, 8'hC3);   // write after write, top address
    do_req(0, 19'h00000, 8'h00);
    do_req(0, 19'h7FFFF, 8'h00);   // read after read
    do_req(1, 19'h12345, 8'h5A);   // write after read: R6
    do_req(0, 19'h12345, 8'h00);
    do_req(0, 19'h12345, 8'h00);   // same address twice
    do_req(1, 19'h00001, 8'hFF);
    do_req(1, 19'h00002, 8'h00);
    do_req(0, 19'h00001, 8'h00);
    do_req(0, 19'h00002, 8'h00);
    for (int i = 0; i < 8; i++) begin
      do_req(1, 19'(i * 4097 + 7), 8'(i * 37 + 1));
      do_req(0, 19'(i * 4097 + 7), 8'h00);
    end
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(1, 19'h7FFFF, 8'h81);
    do_req(0, 19'h7FFFF, 8'h00);
    repeat (12) @(negedge clk);
    check(q.size() == 0, "R5 every request acknowledged", q.size(), 0);
    check(req_ready && ram_cs_n, "R7 idle at end", {req_ready, ram_cs_n}, 2'b11);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule